// File: doc/BRIEF.md
# Floating-Point Control Register File

This block holds the 64-bit control word that steers a floating-point datapath. Software writes a full word through a single write port, and the block keeps only the bits this configuration implements. Reserved positions, and optional fields whose features were left out at elaboration, read as zero and ignore writes. A raw read port always returns the stored word exactly.

Next to the raw read, the block drives "effective" controls for the arithmetic units. These can differ from the stored bits. When the core runs in a streaming vector mode and the full-feature input is low, the six trap enables and the upper-lane-merge control are forced to zero. The read port still shows the stored values. The two-bit rounding field is decoded into a one-hot select. The denormal flush controls are resolved against the alternate-handling bit. The legacy vector length and stride fields can be saved and restored, but they never reach the datapath.

Top module: `fp_ctrl_file`

## Requirements
- R1: While `rstN` is low and after it rises, the stored word is all zeros. Every effective output is zero, except `roundSel`, which is 4'b0001.
- R2: A clock edge with `wrEn` high stores `wrData` masked to the implemented bits, and `rdData` shows the new value from that edge on. A clock edge with `wrEn` low leaves `rdData` unchanged.
- R3: Bits 63:27, bit 14 and bits 7:3 always read as zero, whatever is written to them.
- R4: The rounding field sits at bits 23:22. `roundSel` is one-hot: bit0 means nearest (00), bit1 toward plus infinity (01), bit2 toward minus infinity (10) and bit3 toward zero (11).
- R5: The stride field (bits 21:20) and the length field (bits 18:16) are stored only when `HAS_LEN_STRIDE` is 1, and otherwise read as zero. They never affect any effective output.
- R6: The trap enables sit at bits 8, 9, 10, 11, 12 and 15, and drive `effTrapEn[0]` through `effTrapEn[5]` in that order. Each one reads as zero and ignores writes when its bit of `TRAP_IMPL` is 0.
- R7: The half-precision flush bit (19) needs `HAS_HALF`, the extended bf16 bit (13) needs `HAS_BF_EXT`, and the merge, alternate-handling and input-flush bits (2, 1, 0) need `HAS_ALT`. Each of these bits reads as zero when its parameter is 0.
- R8: When `streamMode` is 1 and `fullFeature` is 0, `effTrapEn` and `effKeepUpper` are zero, while `rdData` keeps returning the stored bits. In every other case they follow the stored bits.
- R9: `effFlushOut` equals bit 24. `effFlushIn` is (bit24 AND NOT bit1) OR bit0.
- R10: `effAltHalf` follows bit 26, `effDefaultNan` follows bit 25, `effFlushHalf` follows bit 19, `effBfExt` follows bit 13 and `effAltMode` follows bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 64 | Word to store |
| streamMode | input | 1 | Core is in streaming vector mode |
| fullFeature | input | 1 | Full instruction set is enabled in streaming mode |
| rdData | output | 64 | Stored word, raw |
| roundSel | output | 4 | One-hot rounding select |
| effAltHalf | output | 1 | Alternative half-precision format |
| effDefaultNan | output | 1 | Return default NaN |
| effFlushIn | output | 1 | Flush denormal inputs |
| effFlushOut | output | 1 | Flush denormal outputs |
| effFlushHalf | output | 1 | Flush half-precision denormals |
| effBfExt | output | 1 | Extended bf16 behaviour |
| effTrapEn | output | 6 | Effective trap enables |
| effKeepUpper | output | 1 | Merge upper lanes from a source register |
| effAltMode | output | 1 | Alternate handling model |

## Verification
Two instances run side by side on the same stimulus. One has every optional field present. The other lacks length/stride, three of the traps and all three feature groups, so the same write shows which bits each build keeps or drops. Random words, combined with random streaming and full-feature inputs, separate the raw read from the gated trap and merge outputs. Directed all-ones writes, the four rounding codes and all four combinations of flush and alternate handling pin down the masks, the decode and the input-flush equation.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int WORD_W = 64;
  localparam int TRAP_N = 6;

  typedef struct packed {
    logic load;
    logic quiet;
  } ctrlStrobe_t;

  function automatic logic [WORD_W-1:0] implMask(
    input bit hasLenStride, input bit [TRAP_N-1:0] trapImpl,
    input bit hasHalf, input bit hasBfExt, input bit hasAlt);
    logic [WORD_W-1:0] m;
    m = '0;
    m[26:22] = 5'b11111;
    if (hasLenStride) begin
      m[21:20] = 2'b11;
      m[18:16] = 3'b111;
    end
    m[19] = hasHalf;
    m[13] = hasBfExt;
    m[12:8] = trapImpl[4:0];
    m[15] = trapImpl[5];
    m[2:0] = {3{hasAlt}};
    return m;
  endfunction

endpackage

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
(
  input  logic        wrEn,
  input  logic        streamMode,
  input  logic        fullFeature,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.load  = wrEn;
    strobe.quiet = streamMode & ~fullFeature;
  end
endmodule

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import fpc_pkg::*;
#(
  parameter bit              HAS_LEN_STRIDE = 1'b1,
  parameter bit [TRAP_N-1:0] TRAP_IMPL      = 6'b111111,
  parameter bit              HAS_HALF       = 1'b1,
  parameter bit              HAS_BF_EXT     = 1'b1,
  parameter bit              HAS_ALT        = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic [3:0]        roundSel,
  output logic              effAltHalf,
  output logic              effDefaultNan,
  output logic              effFlushIn,
  output logic              effFlushOut,
  output logic              effFlushHalf,
  output logic              effBfExt,
  output logic [TRAP_N-1:0] effTrapEn,
  output logic              effKeepUpper,
  output logic              effAltMode
);
  localparam logic [WORD_W-1:0] KEEP_MASK =
    implMask(HAS_LEN_STRIDE, TRAP_IMPL, HAS_HALF, HAS_BF_EXT, HAS_ALT);

  logic [WORD_W-1:0] ctrlWord;
  logic [TRAP_N-1:0] storedTraps;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlWord <= '0;
    else if (strobe.load) ctrlWord <= wrData & KEEP_MASK;
  end

  assign rdData = ctrlWord;

  // rounding decode: one select line per encoding of bits 23:22
  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : gRound
      assign roundSel[g] = (ctrlWord[23:22] == g[1:0]);
    end
  endgenerate

  assign storedTraps  = {ctrlWord[15], ctrlWord[12:8]};
  assign effTrapEn    = strobe.quiet ? '0 : storedTraps;
  assign effKeepUpper = ctrlWord[2] & ~strobe.quiet;

  assign effAltHalf    = ctrlWord[26];
  assign effDefaultNan = ctrlWord[25];
  assign effFlushOut   = ctrlWord[24];
  assign effFlushIn    = (ctrlWord[24] & ~ctrlWord[1]) | ctrlWord[0];
  assign effFlushHalf  = ctrlWord[19];
  assign effBfExt      = ctrlWord[13];
  assign effAltMode    = ctrlWord[1];
endmodule

// File: rtl/fp_ctrl_file.sv
module fp_ctrl_file
  import fpc_pkg::*;
#(
  parameter bit       HAS_LEN_STRIDE = 1'b1,
  parameter bit [5:0] TRAP_IMPL      = 6'b111111,
  parameter bit       HAS_HALF       = 1'b1,
  parameter bit       HAS_BF_EXT     = 1'b1,
  parameter bit       HAS_ALT        = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [63:0] wrData,
  input  logic        streamMode,
  input  logic        fullFeature,
  output logic [63:0] rdData,
  output logic [3:0]  roundSel,
  output logic        effAltHalf,
  output logic        effDefaultNan,
  output logic        effFlushIn,
  output logic        effFlushOut,
  output logic        effFlushHalf,
  output logic        effBfExt,
  output logic [5:0]  effTrapEn,
  output logic        effKeepUpper,
  output logic        effAltMode
);
  ctrlStrobe_t strobe;

  fpc_ctrl uCtrl (
    .wrEn(wrEn), .streamMode(streamMode), .fullFeature(fullFeature), .strobe(strobe)
  );

  fpc_datapath #(
    .HAS_LEN_STRIDE(HAS_LEN_STRIDE), .TRAP_IMPL(TRAP_IMPL),
    .HAS_HALF(HAS_HALF), .HAS_BF_EXT(HAS_BF_EXT), .HAS_ALT(HAS_ALT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdData(rdData),
    .roundSel(roundSel), .effAltHalf(effAltHalf), .effDefaultNan(effDefaultNan),
    .effFlushIn(effFlushIn), .effFlushOut(effFlushOut), .effFlushHalf(effFlushHalf),
    .effBfExt(effBfExt), .effTrapEn(effTrapEn), .effKeepUpper(effKeepUpper),
    .effAltMode(effAltMode)
  );
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker
  import fpc_pkg::*;
#(
  parameter bit       HAS_LEN_STRIDE = 1'b1,
  parameter bit [5:0] TRAP_IMPL      = 6'b111111,
  parameter bit       HAS_HALF       = 1'b1,
  parameter bit       HAS_BF_EXT     = 1'b1,
  parameter bit       HAS_ALT        = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [63:0] wrData,
  input logic        streamMode,
  input logic        fullFeature,
  input logic [63:0] rdData,
  input logic [3:0]  roundSel,
  input logic        effFlushIn,
  input logic        effFlushOut,
  input logic [5:0]  effTrapEn,
  input logic        effKeepUpper
);
  localparam logic [63:0] CHK_MASK =
    implMask(HAS_LEN_STRIDE, TRAP_IMPL, HAS_HALF, HAS_BF_EXT, HAS_ALT);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdData[63:27] == '0 && !rdData[14] && rdData[7:3] == '0);

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & CHK_MASK));

  assert_write_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  assert_round_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(roundSel) && roundSel[rdData[23:22]]);

  assert_stream_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (streamMode && !fullFeature) |-> (effTrapEn == '0 && !effKeepUpper));

  assert_trap_absent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (effTrapEn & ~TRAP_IMPL) == '0);

  assert_flush_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    effFlushOut == rdData[24] && (effFlushIn == ((rdData[24] && !rdData[1]) || rdData[0])));
endmodule

bind fp_ctrl_file fpc_checker #(
  .HAS_LEN_STRIDE(HAS_LEN_STRIDE), .TRAP_IMPL(TRAP_IMPL),
  .HAS_HALF(HAS_HALF), .HAS_BF_EXT(HAS_BF_EXT), .HAS_ALT(HAS_ALT)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .streamMode(streamMode),
  .fullFeature(fullFeature), .rdData(rdData), .roundSel(roundSel),
  .effFlushIn(effFlushIn), .effFlushOut(effFlushOut), .effTrapEn(effTrapEn),
  .effKeepUpper(effKeepUpper)
);

// File: tb/sim_fp_ctrl_file.sv
module sim_fp_ctrl_file;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic streamMode = 1'b0;
  logic fullFeature = 1'b0;

  logic [63:0] rd0, rd1;
  logic [3:0]  rs0, rs1;
  logic [5:0]  tr0, tr1;
  logic ah0, dn0, fi0, fo0, fh0, bf0, ku0, am0;
  logic ah1, dn1, fi1, fo1, fh1, bf1, ku1, am1;

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] exp0 = '0;
  logic [63:0] exp1 = '0;

  always #5 clk = ~clk;

  fp_ctrl_file u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .streamMode(streamMode),
    .fullFeature(fullFeature), .rdData(rd0), .roundSel(rs0), .effAltHalf(ah0),
    .effDefaultNan(dn0), .effFlushIn(fi0), .effFlushOut(fo0), .effFlushHalf(fh0),
    .effBfExt(bf0), .effTrapEn(tr0), .effKeepUpper(ku0), .effAltMode(am0)
  );

  fp_ctrl_file #(
    .HAS_LEN_STRIDE(1'b0), .TRAP_IMPL(6'b010101),
    .HAS_HALF(1'b0), .HAS_BF_EXT(1'b0), .HAS_ALT(1'b0)
  ) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .streamMode(streamMode),
    .fullFeature(fullFeature), .rdData(rd1), .roundSel(rs1), .effAltHalf(ah1),
    .effDefaultNan(dn1), .effFlushIn(fi1), .effFlushOut(fo1), .effFlushHalf(fh1),
    .effBfExt(bf1), .effTrapEn(tr1), .effKeepUpper(ku1), .effAltMode(am1)
  );

  function automatic logic [63:0] keepBits(bit ls, bit [5:0] tr, bit hf, bit bf, bit al);
    logic [63:0] m = '0;
    m[26] = 1; m[25] = 1; m[24] = 1; m[23] = 1; m[22] = 1;
    if (ls) begin m[21] = 1; m[20] = 1; m[18] = 1; m[17] = 1; m[16] = 1; end
    m[19] = hf; m[13] = bf;
    m[8] = tr[0]; m[9] = tr[1]; m[10] = tr[2]; m[11] = tr[3]; m[12] = tr[4]; m[15] = tr[5];
    m[2] = al; m[1] = al; m[0] = al;
    return m;
  endfunction

  localparam logic [63:0] MASK0 = keepBits(1, 6'b111111, 1, 1, 1);
  localparam logic [63:0] MASK1 = keepBits(0, 6'b010101, 0, 0, 0);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare both instances against the bench model of their stored words
  task automatic checkAll(input string ctx);
    logic quiet;
    logic [5:0] t0, t1;
    quiet = streamMode & ~fullFeature;
    t0 = quiet ? 6'b0 : {exp0[15], exp0[12], exp0[11], exp0[10], exp0[9], exp0[8]};
    t1 = quiet ? 6'b0 : {exp1[15], exp1[12], exp1[11], exp1[10], exp1[9], exp1[8]};
    check(rd0 == exp0, {"R2 R3 R5 R7 rd u0 ", ctx}, rd0, exp0);
    check(rd1 == exp1, {"R2 R3 R5 R6 R7 rd u1 ", ctx}, rd1, exp1);
    check(rs0 == (4'b1 << exp0[23:22]), {"R4 round u0 ", ctx}, 64'(rs0), 64'(4'b1 << exp0[23:22]));
    check(rs1 == (4'b1 << exp1[23:22]), {"R4 round u1 ", ctx}, 64'(rs1), 64'(4'b1 << exp1[23:22]));
    check(tr0 == t0 && ku0 == (exp0[2] & ~quiet), {"R8 R6 gate u0 ", ctx}, {57'b0, ku0, tr0}, {57'b0, exp0[2] & ~quiet, t0});
    check(tr1 == t1 && ku1 == 1'b0, {"R6 R8 gate u1 ", ctx}, {57'b0, ku1, tr1}, {57'b0, 1'b0, t1});
    check(fo0 == exp0[24] && fi0 == ((exp0[24] & ~exp0[1]) | exp0[0]),
          {"R9 flush u0 ", ctx}, {62'b0, fo0, fi0}, {62'b0, exp0[24], (exp0[24] & ~exp0[1]) | exp0[0]});
    check(fo1 == exp1[24] && fi1 == exp1[24], {"R9 flush u1 ", ctx}, {62'b0, fo1, fi1}, {62'b0, exp1[24], exp1[24]});
    check({ah0, dn0, fh0, bf0, am0} == {exp0[26], exp0[25], exp0[19], exp0[13], exp0[1]},
          {"R10 pass u0 ", ctx}, {59'b0, ah0, dn0, fh0, bf0, am0}, {59'b0, exp0[26], exp0[25], exp0[19], exp0[13], exp0[1]});
    check({ah1, dn1, fh1, bf1, am1} == {exp1[26], exp1[25], 3'b000},
          {"R10 R7 pass u1 ", ctx}, {59'b0, ah1, dn1, fh1, bf1, am1}, {59'b0, exp1[26], exp1[25], 3'b000});
  endtask

  // drive on falling edge, let a rising edge pass, check on next falling edge
  task automatic step(input bit we, input logic [63:0] d, input bit sm, input bit ff, input string ctx);
    wrEn = we; wrData = d; streamMode = sm; fullFeature = ff;
    @(negedge clk);
    if (we) begin exp0 = d & MASK0; exp1 = d & MASK1; end
    checkAll(ctx);
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0f1c));
    wrEn = 1'b1; wrData = '1;
    @(negedge clk); @(negedge clk);
    checkAll("R1 reset held");
    rstN = 1'b1; wrEn = 1'b0;
    @(negedge clk);
    checkAll("R1 after reset");

    step(1, '1, 0, 0, "all ones");
    step(0, '0, 0, 0, "R2 hold");
    step(0, '0, 1, 0, "R8 streaming gate");
    step(0, '0, 1, 1, "R8 full feature");
    step(1, 64'h0000_0000_0037_0000, 0, 0, "R5 len stride only");
    for (int r = 0; r < 4; r++) step(1, 64'(r) << 22, 0, 0, "R4 round code");
    step(1, 64'h0100_0000, 0, 0, "R9 fz only");
    step(1, 64'h0100_0002, 0, 0, "R9 fz ah");
    step(1, 64'h0000_0001, 0, 0, "R9 fiz only");
    step(1, 64'h0100_0003, 0, 0, "R9 fz ah fiz");
    step(1, 64'h0000_9F04, 1, 0, "R6 R8 traps streaming");
    step(1, ~64'h0000_0000_07FF_BF07, 0, 0, "R3 reserved only");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      step(($urandom % 3) != 0, d, $urandom % 2, $urandom % 2, "random");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule